// File: doc/BRIEF.md
# I/O port permission checker

This block rules on whether a single I/O port access may proceed or must raise a general-protection fault. A request carries a 16-bit port address and a size code. It also carries the current and I/O privilege levels, flags for protected mode and virtual-8086 mode, the offset of the permission bitmap inside the task segment, and the limit of that segment. Some cases can be settled from the privilege state and the request fields alone. Those requests are answered on the cycle after acceptance.

All other requests need a bitmap lookup. For these, the block reads one 16-bit word from a synchronous read port that models the task segment. It masks off any byte that lies past the segment limit. It then tests every bitmap bit covering the ports the access touches, and pulses grant or fault. While a lookup is in flight the block refuses new requests. It becomes ready again on the cycle its verdict appears, so a follow-up request can be accepted in that same cycle.

Top module: `ioperm_gate`

## Requirements
- R1: With `req_prot` low, every accepted request pulses `grant` on the cycle after acceptance, and no memory read is issued.
- R2: With `req_prot` high, `req_v86` low and `req_cpl` <= `req_iopl`, a valid in-range request is granted on the cycle after acceptance, without a memory read.
- R3: A bitmap lookup is needed when `req_cpl` > `req_iopl`, or when `req_v86` is high, in protected mode. The block then reads the word at byte offset `map_base + (port >> 3)`. The byte at the lower offset sits in `mem_rd_data[7:0]` and the next byte in `[15:8]`. The bit for port P is bit P&7 of the lower byte.
- R4: Size code 0 covers 1 port, code 1 covers 2 ports and code 2 covers 4 consecutive ports, starting at the request port. Every covered bit is tested, including bits that cross into the upper fetched byte. Any set bit gives `fault`; if all are clear, the result is `grant`.
- R5: A fetched byte whose offset is greater than `seg_limit` is treated as 8'hFF.
- R6: When a lookup is needed and `map_base` >= `seg_limit`, the request faults on the cycle after acceptance, with no memory read.
- R7: When a lookup is needed and `map_base` exceeds the `MAX_BASE` parameter (default 16'hDFFF), the request faults on the cycle after acceptance, with no memory read.
- R8: In protected mode, a request faults on the cycle after acceptance, with no memory read, in two cases: size code 3, or a last covered port (port + bytes - 1) above 16'hFFFF. These checks come before the privilege test.
- R9: For a lookup, `mem_rd_en` is high for exactly the one cycle after acceptance, and the verdict pulses two cycles after that. Every request yields exactly one one-cycle pulse on `grant` or `fault`, never both at once.
- R10: A request is accepted only on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low while a lookup is pending and high again in the cycle its verdict pulses. Requests offered while it is low have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request will be taken |
| req_port | input | 16 | First port address of the access |
| req_size | input | 2 | Size code: 0 byte, 1 word, 2 doubleword, 3 invalid |
| req_cpl | input | 2 | Current privilege level |
| req_iopl | input | 2 | I/O privilege level |
| req_prot | input | 1 | Protected mode active |
| req_v86 | input | 1 | Virtual-8086 mode active |
| map_base | input | 16 | Bitmap byte offset within the task segment |
| seg_limit | input | 16 | Offset of the last valid task-segment byte |
| mem_rd_en | output | 1 | Task-segment word read strobe |
| mem_rd_addr | output | 16 | Byte offset of the lower fetched byte |
| mem_rd_data | input | 16 | Read word, valid the cycle after the strobe |
| grant | output | 1 | One-cycle pulse: access allowed |
| fault | output | 1 | One-cycle pulse: general-protection fault |

## Verification
The verdict pulse of a finished lookup and the acceptance of the next request can land in the same cycle. The bench provokes this by starting a lookup that must fault, then holding a real-mode request on the inputs throughout the busy window. It checks three things. The held request has no effect while `req_ready` is low. The fault pulses on schedule while `req_ready` rises. The held request is accepted on that same edge and is granted one cycle later. The table-driven part covers each reason for fault, or for no read, with its expected latency and read address.

// File: rtl/ioperm_pkg.sv
package ioperm_pkg;

    localparam int PORT_W = 16;
    localparam int OFS_W  = 16;
    localparam int WORD_W = 16;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_DWORD = 2'd2,
        SZ_BAD   = 2'd3
    } size_e;

    typedef enum logic [1:0] {
        V_GRANT,
        V_FAULT,
        V_LOOKUP
    } verdict_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_WAIT
    } state_e;

    typedef struct packed {
        logic [OFS_W-1:0] off;
        logic [2:0]       bitpos;
        size_e            size;
        logic             ok_lo;
        logic             ok_hi;
    } lookup_t;

    function automatic logic [2:0] size_bytes(size_e s);
        case (s)
            SZ_BYTE:  return 3'd1;
            SZ_WORD:  return 3'd2;
            SZ_DWORD: return 3'd4;
            default:  return 3'd0;
        endcase
    endfunction

    function automatic logic [3:0] size_mask(size_e s);
        case (s)
            SZ_BYTE:  return 4'b0001;
            SZ_WORD:  return 4'b0011;
            SZ_DWORD: return 4'b1111;
            default:  return 4'b1111;
        endcase
    endfunction

endpackage

// File: rtl/ioperm_classify.sv
module ioperm_classify
    import ioperm_pkg::*;
#(
    parameter logic [OFS_W-1:0] MAX_BASE = 16'hDFFF
) (
    input  logic [PORT_W-1:0] port,
    input  size_e             size,
    input  logic [1:0]        cpl,
    input  logic [1:0]        iopl,
    input  logic              prot,
    input  logic              v86,
    input  logic [OFS_W-1:0]  base,
    input  logic [OFS_W-1:0]  limit,
    output verdict_e          verdict,
    output lookup_t           lk
);
    localparam int EXT_W = (PORT_W > OFS_W ? PORT_W : OFS_W) + 1;
    localparam logic [EXT_W-1:0] PORT_MAX = EXT_W'({PORT_W{1'b1}});

    logic [EXT_W-1:0] last_port;
    logic [EXT_W-1:0] off_lo;
    logic [EXT_W-1:0] off_hi;
    logic [EXT_W-1:0] lim_x;
    logic             need_map;

    always_comb begin
        last_port = EXT_W'(port) + EXT_W'(size_bytes(size)) - EXT_W'(1);
        off_lo    = EXT_W'(base) + EXT_W'(port >> 3);
        off_hi    = off_lo + EXT_W'(1);
        lim_x     = EXT_W'(limit);
        need_map  = v86 || (cpl > iopl);

        lk.off    = off_lo[OFS_W-1:0];
        lk.bitpos = port[2:0];
        lk.size   = size;
        lk.ok_lo  = (off_lo <= lim_x);
        lk.ok_hi  = (off_hi <= lim_x);

        if (!prot)
            verdict = V_GRANT;
        else if (size == SZ_BAD || last_port > PORT_MAX)
            verdict = V_FAULT;
        else if (!need_map)
            verdict = V_GRANT;
        else if (base > MAX_BASE || base >= limit)
            verdict = V_FAULT;
        else
            verdict = V_LOOKUP;
    end
endmodule

// File: rtl/ioperm_window.sv
module ioperm_window
    import ioperm_pkg::*;
(
    input  logic [WORD_W-1:0] raw,
    input  logic              ok_lo,
    input  logic              ok_hi,
    input  logic [2:0]        bitpos,
    input  size_e             size,
    output logic              deny
);
    logic [WORD_W-1:0] win;
    logic [3:0]        need;

    always_comb begin
        win[7:0]  = ok_lo ? raw[7:0]  : 8'hFF;
        win[15:8] = ok_hi ? raw[15:8] : 8'hFF;
        need      = size_mask(size);
        deny      = 1'b0;
        for (int i = 0; i < 4; i++) begin
            deny = deny | (need[i] & win[4'({1'b0, bitpos}) + 4'(i)]);
        end
    end
endmodule

// File: rtl/ioperm_gate.sv
module ioperm_gate
    import ioperm_pkg::*;
#(
    parameter logic [OFS_W-1:0] MAX_BASE = 16'hDFFF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [PORT_W-1:0] req_port,
    input  logic [1:0]        req_size,
    input  logic [1:0]        req_cpl,
    input  logic [1:0]        req_iopl,
    input  logic              req_prot,
    input  logic              req_v86,
    input  logic [OFS_W-1:0]  map_base,
    input  logic [OFS_W-1:0]  seg_limit,
    output logic              mem_rd_en,
    output logic [OFS_W-1:0]  mem_rd_addr,
    input  logic [WORD_W-1:0] mem_rd_data,
    output logic              grant,
    output logic              fault
);
    state_e   state;
    lookup_t  pend;
    verdict_e verdict;
    lookup_t  lk_new;
    logic     deny;
    logic     grant_q;
    logic     fault_q;
    logic     accept;

    ioperm_classify #(.MAX_BASE(MAX_BASE)) u_classify (
        .port    (req_port),
        .size    (size_e'(req_size)),
        .cpl     (req_cpl),
        .iopl    (req_iopl),
        .prot    (req_prot),
        .v86     (req_v86),
        .base    (map_base),
        .limit   (seg_limit),
        .verdict (verdict),
        .lk      (lk_new)
    );

    ioperm_window u_window (
        .raw    (mem_rd_data),
        .ok_lo  (pend.ok_lo),
        .ok_hi  (pend.ok_hi),
        .bitpos (pend.bitpos),
        .size   (pend.size),
        .deny   (deny)
    );

    assign req_ready   = (state == ST_IDLE);
    assign accept      = req_valid && req_ready;
    assign mem_rd_en   = (state == ST_READ);
    assign mem_rd_addr = pend.off;
    assign grant       = grant_q;
    assign fault       = fault_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            pend    <= '0;
            grant_q <= 1'b0;
            fault_q <= 1'b0;
        end else begin
            grant_q <= 1'b0;
            fault_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        case (verdict)
                            V_GRANT:  grant_q <= 1'b1;
                            V_LOOKUP: begin
                                pend  <= lk_new;
                                state <= ST_READ;
                            end
                            default:  fault_q <= 1'b1;
                        endcase
                    end
                end
                ST_READ: state <= ST_WAIT;
                ST_WAIT: begin
                    grant_q <= !deny;
                    fault_q <= deny;
                    state   <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ioperm_gate_chk.sv
module ioperm_gate_chk
    import ioperm_pkg::*;
#(
    parameter logic [OFS_W-1:0] MAX_BASE = 16'hDFFF
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_ready,
    input logic [1:0]       req_size,
    input logic [1:0]       req_cpl,
    input logic [1:0]       req_iopl,
    input logic             req_prot,
    input logic             req_v86,
    input logic [OFS_W-1:0] map_base,
    input logic [OFS_W-1:0] seg_limit,
    input logic             mem_rd_en,
    input logic             grant,
    input logic             fault
);
    logic acc;
    logic lookup_kind;
    assign acc         = req_valid && req_ready;
    assign lookup_kind = acc && req_prot && (req_size != 2'd3) && (req_v86 || req_cpl > req_iopl);

    // R9
    one_result_chk: assert property (@(posedge clk) disable iff (rst) !(grant && fault));

    // R9
    rd_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |-> $past(acc));

    // R9
    result_after_read_chk: assert property (@(posedge clk) disable iff (rst)
        $past(mem_rd_en, 2) |-> (grant ^ fault));

    // R10
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |-> !req_ready);

    // R1
    realmode_grant_chk: assert property (@(posedge clk) disable iff (rst)
        (acc && !req_prot) |=> (grant && !mem_rd_en));

    // R7
    bad_base_chk: assert property (@(posedge clk) disable iff (rst)
        (lookup_kind && map_base > MAX_BASE) |=> (fault && !mem_rd_en));

    // R6
    no_map_chk: assert property (@(posedge clk) disable iff (rst)
        (lookup_kind && map_base >= seg_limit) |=> (fault && !mem_rd_en));
endmodule

bind ioperm_gate ioperm_gate_chk #(.MAX_BASE(MAX_BASE)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_size  (req_size),
    .req_cpl   (req_cpl),
    .req_iopl  (req_iopl),
    .req_prot  (req_prot),
    .req_v86   (req_v86),
    .map_base  (map_base),
    .seg_limit (seg_limit),
    .mem_rd_en (mem_rd_en),
    .grant     (grant),
    .fault     (fault)
);

// File: tb/ioperm_gate_test.sv
`timescale 1ns/1ps
module ioperm_gate_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [15:0] req_port = '0;
    logic [1:0]  req_size = '0;
    logic [1:0]  req_cpl = '0;
    logic [1:0]  req_iopl = '0;
    logic        req_prot = 1'b0;
    logic        req_v86 = 1'b0;
    logic [15:0] map_base = '0;
    logic [15:0] seg_limit = '0;
    logic        mem_rd_en;
    logic [15:0] mem_rd_addr;
    logic [15:0] mem_rd_data;
    logic        grant;
    logic        fault;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    ioperm_gate uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_port(req_port), .req_size(req_size), .req_cpl(req_cpl),
        .req_iopl(req_iopl), .req_prot(req_prot), .req_v86(req_v86),
        .map_base(map_base), .seg_limit(seg_limit), .mem_rd_en(mem_rd_en),
        .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .grant(grant), .fault(fault)
    );

    // task-segment model: 1 KiB, address wraps
    logic [7:0] tmem [1024];
    logic [9:0] ta;
    assign ta = mem_rd_addr[9:0];
    always_ff @(posedge clk) begin
        if (mem_rd_en) mem_rd_data <= {tmem[ta + 10'd1], tmem[ta]};
    end

    localparam logic [15:0] B = 16'h0100;
    localparam logic [15:0] L = 16'h010A;
    localparam int NV = 21;
    localparam logic [15:0] V_PORT [NV] = '{16'h0029, 16'h0028, 16'h0028, 16'h002A, 16'h0026,
        16'h0016, 16'h0015, 16'h0056, 16'h0057, 16'h0058, 16'h0029, 16'h0029, 16'h0028,
        16'h0029, 16'h0000, 16'h0000, 16'hFFFE, 16'hFFFF, 16'h0000, 16'h0029, 16'h0000};
    localparam logic [1:0] V_SIZE [NV] = '{0,0,1,2,2, 1,1,1,1,0, 0,0,0,0,0, 0,2,0,3,0, 0};
    localparam logic [1:0] V_CPL  [NV] = '{3,3,3,3,3, 3,3,3,3,3, 0,0,0,3,3, 3,0,0,0,2, 3};
    localparam logic [1:0] V_IOPL [NV] = '{0,0,0,0,0, 0,0,0,0,0, 3,3,3,0,0, 0,3,3,3,2, 0};
    localparam logic V_PROT [NV] = '{1,1,1,1,1, 1,1,1,1,1, 1,1,1,0,1, 1,1,1,1,1, 1};
    localparam logic V_V86  [NV] = '{0,0,0,0,0, 0,0,0,0,0, 0,1,1,0,0, 0,0,0,0,0, 0};
    localparam logic [15:0] V_BASE [NV] = '{B,B,B,B,B, B,B,B,B,B, B,B,B,B,16'h010A,
        16'hE000,B,B,B,B, 16'hDFFF};
    localparam logic [15:0] V_LIM  [NV] = '{L,L,L,L,L, L,L,L,L,L, L,L,L,L,16'h010A,
        16'hFFFF,L,L,L,L, 16'hFFFF};
    localparam logic V_GRANT [NV] = '{0,1,0,1,0, 0,1,1,0,0, 1,0,1,1,0, 0,0,1,0,1, 1};
    localparam logic V_READ  [NV] = '{1,1,1,1,1, 1,1,1,1,1, 0,1,1,0,0, 0,0,0,0,0, 1};

    function automatic string tag_of(int i);
        case (i)
            0, 1, 2, 3, 4, 5, 6: return "R4";
            7, 8, 9:             return "R5";
            10, 19:              return "R2";
            11, 12:              return "R3";
            13:                  return "R1";
            14:                  return "R6";
            15, 20:              return "R7";
            default:             return "R8";
        endcase
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic run_case(int i);
        int rd_k = 0;
        int res_k = 0;
        logic g = 0;
        logic f = 0;
        logic [15:0] a = '0;
        logic [15:0] exp_a;
        int exp_k;
        @(negedge clk);
        req_port = V_PORT[i]; req_size = V_SIZE[i]; req_cpl = V_CPL[i];
        req_iopl = V_IOPL[i]; req_prot = V_PROT[i]; req_v86 = V_V86[i];
        map_base = V_BASE[i]; seg_limit = V_LIM[i]; req_valid = 1'b1;
        @(posedge clk);
        for (int k = 1; k <= 5; k++) begin
            @(negedge clk);
            req_valid = 1'b0;
            if (mem_rd_en && rd_k == 0) begin rd_k = k; a = mem_rd_addr; end
            if ((grant || fault) && res_k == 0) begin res_k = k; g = grant; f = fault; end
            if (res_k != 0) break;
        end
        exp_k = V_READ[i] ? 3 : 1;
        exp_a = V_BASE[i] + (V_PORT[i] >> 3);
        chk(g == V_GRANT[i] && f == !V_GRANT[i], tag_of(i), $sformatf("verdict case %0d", i),
            {g, f}, {V_GRANT[i], !V_GRANT[i]});
        chk((rd_k != 0) == V_READ[i], tag_of(i), $sformatf("read issued case %0d", i),
            int'(rd_k != 0), int'(V_READ[i]));
        // R9 latency
        chk(res_k == exp_k, "R9", $sformatf("latency case %0d", i), res_k, exp_k);
        if (V_READ[i]) begin
            // R3 read address
            chk(a == exp_a && rd_k == 1, "R3", $sformatf("read addr case %0d", i), a, exp_a);
        end
    endtask

    initial begin
        for (int j = 0; j < 1024; j++) tmem[j] = 8'h00;
        tmem[10'h105] = 8'h02;  // port 0x29 denied
        tmem[10'h102] = 8'h80;  // port 0x17 denied
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk(req_ready == 1'b1, "R10", "ready after reset", req_ready, 1);
        chk(!grant && !fault && !mem_rd_en, "R9", "outputs quiet after reset",
            {grant, fault, mem_rd_en}, 0);

        for (int i = 0; i < NV; i++) run_case(i);

        // R10: result of a lookup and acceptance of the next request in one cycle
        @(negedge clk);
        req_port = 16'h0029; req_size = 2'd0; req_cpl = 2'd3; req_iopl = 2'd0;
        req_prot = 1'b1; req_v86 = 1'b0; map_base = B; seg_limit = L; req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);                  // C1: read cycle, busy
        req_prot = 1'b0; req_port = 16'h0000;   // held request, must wait
        chk(mem_rd_en && !req_ready, "R10", "busy during read", {mem_rd_en, req_ready}, 2'b10);
        @(negedge clk);                  // C2
        chk(!grant && !fault, "R10", "held request ignored while busy", {grant, fault}, 0);
        @(negedge clk);                  // C3: verdict plus ready
        chk(fault && !grant && req_ready, "R10", "fault with ready in same cycle",
            {fault, grant, req_ready}, 3'b101);
        @(negedge clk);                  // C4: held request answered
        req_valid = 1'b0;
        chk(grant && !fault, "R1", "held real-mode request granted", {grant, fault}, 2'b10);
        @(negedge clk);
        chk(!grant && !fault, "R9", "single pulse only", {grant, fault}, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule